// File: doc/BRIEF.md
# Command-Framed SPI Slave with Status Flow Control

This block connects an external SPI master to two byte buffers inside the chip: a transmit buffer the block reads from and a receive buffer it writes into. Every selection of the slave starts with a command byte that chooses the direction of the transfer. While the command and any following bytes are shifted in, the slave shifts out status bytes that tell the master whether the receive side can take more data and whether the transmit side holds anything to read. Once the command is in, the master can keep clocking byte slots for as long as slave select stays low. On a write each slot carries one data byte, and on a read each slot returns one buffered byte until the buffer runs dry.

SCLK, slave select and MOSI are brought into the system clock domain through two-flop synchronisers. Edges are detected there, so the system clock must run several times faster than SCLK. Clock polarity and phase come from two configuration inputs. The block takes them only while the slave is deselected, so a change made during a transfer has no effect. MISO is given with a separate output enable, which is low whenever the slave is not selected.

Top module: `spi_cmd_slave`

## Requirements
- R1: `spi_miso_oe` is 0 while `spi_ss_n` is high and is 1 while the slave is selected. A transaction lasts only while `spi_ss_n` stays low.
- R2: The first byte after `spi_ss_n` falls is a command, sent MSB first. Command bit 7 (the first bit on the wire) equal to 1 selects read and 0 selects write. Bits 6..0 have no effect.
- R3: Every status byte has bit 0 = `rx_full` (1 means writes are refused) and bit 1 = 1 when `tx_valid` is 0 (nothing to read). Bits 7..2 are 0. Each status byte is captured at the start of its byte slot. The command slot always returns status on MISO.
- R4: After a write command, each complete data byte is presented on `rx_data` with a one-cycle `rx_push`, provided the status in that slot showed bit 0 = 0. Any number of bytes may follow one command, and each write data slot returns status on MISO.
- R5: A write data byte in a slot whose status showed bit 0 = 1 is discarded, and no `rx_push` occurs.
- R6: After a read command, each slot that begins with `tx_valid` = 1 returns `tx_data` MSB first and pulses `tx_pop` once. A slot that begins with `tx_valid` = 0 returns a status byte and does not pop.
- R7: All four modes are supported. `cfg_cpol` is the SCLK idle level. With `cfg_cpha` = 0, data is sampled on the leading edge and the first MISO bit is valid once selected. With `cfg_cpha` = 1, data is sampled on the trailing edge.
- R8: `cfg_cpol` and `cfg_cpha` are taken only while the slave is deselected. A change during a transaction has no effect on it.
- R9: Raising `spi_ss_n` in the middle of a byte drops the partial byte without a push. The next selection starts again with a command byte.
- R10: After synchronous reset, `spi_miso_oe`, `rx_push` and `tx_pop` are 0.
- R11: `rx_push` and `tx_pop` are single-cycle pulses, at most one per byte slot, and never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cpol | input | 1 | SCLK idle level, taken while deselected |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| spi_sclk | input | 1 | SPI serial clock from the master |
| spi_ss_n | input | 1 | Active-low slave select |
| spi_mosi | input | 1 | Master-out serial data |
| spi_miso | output | 1 | Slave-out serial data |
| spi_miso_oe | output | 1 | Output enable for MISO, low when deselected |
| tx_data | input | DW | Head byte of the transmit buffer |
| tx_valid | input | 1 | Transmit buffer not empty |
| tx_pop | output | 1 | Removes the head byte of the transmit buffer |
| rx_data | output | DW | Byte committed to the receive buffer |
| rx_push | output | 1 | Writes `rx_data` into the receive buffer |
| rx_full | input | 1 | Receive buffer cannot accept a byte |

## Verification
The bound checker checks on every cycle that pushes and pops are isolated one-cycle pulses and never coincide, that a pop only follows a cycle with data available, that a push happens only while MISO is enabled, and that the latched mode changes only after a deselected cycle. The bench's transactions are the only evidence for the framing itself: the status encoding in each slot, direction decode with varied low command bits, streaming of several bytes per command, discard when the receive side is full, fallback to status once the transmit buffer empties, correct shifting in all four modes, mode changes ignored mid-transfer, and recovery after an aborted byte.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  // status byte field positions
  localparam int ST_RXFULL_BIT  = 0;
  localparam int ST_TXEMPTY_BIT = 1;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_CMD,
    PH_WR,
    PH_RD
  } phase_e;
endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync #(
  parameter int          W      = 3,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= d;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[g] <= RST_VAL;
      else     stg[g] <= stg[g-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_cmd_phase.sv
module spi_cmd_phase (
  input  logic       clk,
  input  logic       rst,
  input  logic       sclk_s,
  input  logic       ss_n_s,
  input  logic       cfg_cpol,
  input  logic       cfg_cpha,
  output logic       sel,
  output logic       sel_start,
  output logic       sample_stb,
  output logic       shift_stb,
  output logic [1:0] mode_q
);
  logic sclk_d, sel_d;
  logic rise, fall, lead, trail;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      sel_d  <= 1'b0;
      mode_q <= 2'b00;
    end else begin
      sclk_d <= sclk_s;
      sel_d  <= ~ss_n_s;
      if (ss_n_s) mode_q <= {cfg_cpol, cfg_cpha};
    end
  end

  assign rise  = sclk_s & ~sclk_d;
  assign fall  = ~sclk_s & sclk_d;
  assign lead  = mode_q[1] ? fall : rise;
  assign trail = mode_q[1] ? rise : fall;

  assign sel        = ~ss_n_s;
  assign sel_start  = sel & ~sel_d;
  assign sample_stb = sel & ~sel_start & (mode_q[0] ? trail : lead);
  assign shift_stb  = sel & ~sel_start & (mode_q[0] ? lead : trail);
endmodule

// File: rtl/spi_cmd_frame.sv
module spi_cmd_frame
  import spi_cmd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel,
  input  logic          sel_start,
  input  logic          sample_stb,
  input  logic          shift_stb,
  input  logic          mosi_s,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_valid,
  input  logic          rx_full,
  output logic          miso,
  output logic          miso_oe,
  output logic          tx_pop,
  output logic [DW-1:0] rx_data,
  output logic          rx_push
);
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  phase_e        phase_q, next_ph;
  logic [CW-1:0] bit_cnt;
  logic [DW-2:0] rx_sr;
  logic [DW-1:0] tx_sr;
  logic [DW-1:0] stat;
  logic [DW-1:0] byte_in;
  logic          wr_ok_q;
  logic          last_bit;

  always_comb begin
    stat = '0;
    stat[ST_RXFULL_BIT]  = rx_full;
    stat[ST_TXEMPTY_BIT] = ~tx_valid;
  end

  assign byte_in  = {rx_sr, mosi_s};
  assign last_bit = sample_stb && (bit_cnt == LAST);

  always_comb begin
    next_ph = phase_q;
    if (phase_q == PH_CMD) next_ph = byte_in[DW-1] ? PH_RD : PH_WR;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      bit_cnt <= '0;
      rx_sr   <= '0;
      tx_sr   <= '0;
      wr_ok_q <= 1'b0;
      tx_pop  <= 1'b0;
      rx_push <= 1'b0;
      rx_data <= '0;
      miso_oe <= 1'b0;
    end else begin
      tx_pop  <= 1'b0;
      rx_push <= 1'b0;
      miso_oe <= sel;
      if (!sel) begin
        phase_q <= PH_IDLE;
        bit_cnt <= '0;
      end else if (sel_start) begin
        phase_q <= PH_CMD;
        bit_cnt <= '0;
        tx_sr   <= stat;
        wr_ok_q <= ~rx_full;
      end else begin
        if (shift_stb && bit_cnt != '0) tx_sr <= {tx_sr[DW-2:0], 1'b0};
        if (sample_stb) begin
          rx_sr   <= byte_in[DW-2:0];
          bit_cnt <= last_bit ? '0 : bit_cnt + 1'b1;
        end
        if (last_bit) begin
          if (phase_q == PH_WR && wr_ok_q) begin
            rx_data <= byte_in;
            rx_push <= 1'b1;
          end
          if (next_ph == PH_RD && tx_valid) begin
            tx_sr  <= tx_data;
            tx_pop <= 1'b1;
          end else begin
            tx_sr  <= stat;
          end
          wr_ok_q <= ~rx_full;
          phase_q <= next_ph;
        end
      end
    end
  end

  assign miso = tx_sr[DW-1];
endmodule

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave #(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_cpol,
  input  logic          cfg_cpha,
  input  logic          spi_sclk,
  input  logic          spi_ss_n,
  input  logic          spi_mosi,
  output logic          spi_miso,
  output logic          spi_miso_oe,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_valid,
  output logic          tx_pop,
  output logic [DW-1:0] rx_data,
  output logic          rx_push,
  input  logic          rx_full
);
  logic [2:0] pins_s;
  logic       sel, sel_start, sample_stb, shift_stb;
  logic [1:0] mode_q;

  spi_cmd_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({spi_sclk, spi_ss_n, spi_mosi}),
    .q   (pins_s)
  );

  spi_cmd_phase u_phase (
    .clk        (clk),
    .rst        (rst),
    .sclk_s     (pins_s[2]),
    .ss_n_s     (pins_s[1]),
    .cfg_cpol   (cfg_cpol),
    .cfg_cpha   (cfg_cpha),
    .sel        (sel),
    .sel_start  (sel_start),
    .sample_stb (sample_stb),
    .shift_stb  (shift_stb),
    .mode_q     (mode_q)
  );

  spi_cmd_frame #(.DW(DW)) u_frame (
    .clk        (clk),
    .rst        (rst),
    .sel        (sel),
    .sel_start  (sel_start),
    .sample_stb (sample_stb),
    .shift_stb  (shift_stb),
    .mosi_s     (pins_s[0]),
    .tx_data    (tx_data),
    .tx_valid   (tx_valid),
    .rx_full    (rx_full),
    .miso       (spi_miso),
    .miso_oe    (spi_miso_oe),
    .tx_pop     (tx_pop),
    .rx_data    (rx_data),
    .rx_push    (rx_push)
  );
endmodule

// File: rtl/spi_cmd_slave_chk.sv
module spi_cmd_slave_chk (
  input logic       clk,
  input logic       rst,
  input logic       miso_oe,
  input logic       tx_valid,
  input logic       tx_pop,
  input logic       rx_push,
  input logic       sel,
  input logic [1:0] mode_q
);
  // R11
  rx_push_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_push |=> !rx_push);

  // R11
  tx_pop_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    tx_pop |=> !tx_pop);

  // R11
  push_pop_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(rx_push && tx_pop));

  // R6
  pop_needs_data_chk: assert property (@(posedge clk) disable iff (rst)
    tx_pop |-> $past(tx_valid));

  // R4
  push_while_sel_chk: assert property (@(posedge clk) disable iff (rst)
    rx_push |-> miso_oe);

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(mode_q) |-> !$past(sel));
endmodule

bind spi_cmd_slave spi_cmd_slave_chk chk_i (
  .clk      (clk),
  .rst      (rst),
  .miso_oe  (spi_miso_oe),
  .tx_valid (tx_valid),
  .tx_pop   (tx_pop),
  .rx_push  (rx_push),
  .sel      (sel),
  .mode_q   (mode_q)
);

// File: tb/spi_cmd_slave_tb_top.sv
`timescale 1ns/1ps
module spi_cmd_slave_tb_top;
  localparam int H = 8;  // system cycles per SCLK half period

  typedef struct packed {
    logic       cpol;
    logic       cpha;
    logic       full;
    logic [1:0] avail;
    logic [7:0] cmd;
    logic [7:0] d0;
    logic [7:0] stat;
  } vec_t;

  // cpol cpha full avail cmd d0 expected-status
  localparam vec_t VECS [8] = '{
    '{1'b0, 1'b0, 1'b0, 2'd0, 8'h00, 8'hA1, 8'h02},
    '{1'b0, 1'b1, 1'b0, 2'd2, 8'h80, 8'h3C, 8'h00},
    '{1'b1, 1'b0, 1'b1, 2'd0, 8'h7F, 8'h55, 8'h03},
    '{1'b1, 1'b1, 1'b0, 2'd0, 8'hFF, 8'h00, 8'h02},
    '{1'b1, 1'b1, 1'b0, 2'd0, 8'h2A, 8'hE0, 8'h02},
    '{1'b1, 1'b0, 1'b1, 2'd1, 8'h9B, 8'hC3, 8'h01},
    '{1'b0, 1'b1, 1'b1, 2'd0, 8'h40, 8'h10, 8'h03},
    '{1'b0, 1'b0, 1'b0, 2'd2, 8'hC0, 8'hFE, 8'h00}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_cpol = 1'b0, cfg_cpha = 1'b0;
  logic sclk = 1'b0, ss_n = 1'b1, mosi = 1'b0;
  logic miso, miso_oe;
  logic [7:0] tx_data, rx_data;
  logic tx_valid, tx_pop, rx_push;
  logic rx_full = 1'b0;
  logic m_cpol = 1'b0, m_cpha = 1'b0;

  int errors = 0, checks = 0;
  bit done = 0;

  logic [7:0] txq [64];
  logic [7:0] rxq [64];
  int tx_wr = 0, tx_rd = 0, rx_wr = 0;

  always #10 clk = ~clk;

  assign tx_valid = (tx_wr != tx_rd);
  assign tx_data  = txq[tx_rd % 64];

  always @(posedge clk) begin
    if (!rst) begin
      if (tx_pop) tx_rd <= tx_rd + 1;
      if (rx_push) begin
        rxq[rx_wr % 64] <= rx_data;
        rx_wr <= rx_wr + 1;
      end
    end
  end

  spi_cmd_slave dut_i (
    .clk(clk), .rst(rst), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .spi_sclk(sclk), .spi_ss_n(ss_n), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(miso_oe),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_pop(tx_pop),
    .rx_data(rx_data), .rx_push(rx_push), .rx_full(rx_full)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(input logic p, input logic h);
    m_cpol = p; m_cpha = h;
    cfg_cpol = p; cfg_cpha = h;
    sclk = p;
    cyc(6);
  endtask

  task automatic xfer_byte(input logic [7:0] o, output logic [7:0] r, input int nbits = 8);
    r = '0;
    for (int i = 7; i >= 8 - nbits; i--) begin
      if (!m_cpha) begin
        mosi = o[i]; cyc(H);
        r[i] = miso; sclk = ~m_cpol; cyc(H);
        sclk = m_cpol;
      end else begin
        sclk = ~m_cpol; mosi = o[i]; cyc(H);
        r[i] = miso; sclk = m_cpol; cyc(H);
      end
    end
  endtask

  task automatic end_xfer();
    cyc(H);
    ss_n = 1'b1;
    cyc(2 * H);
  endtask

  initial begin
    logic [7:0] r;
    logic [7:0] exp;
    int rx0, pop0;
    vec_t t;

    cyc(3);
    // R10 during reset
    check("R10 miso_oe in reset", miso_oe, 0);
    rst = 1'b0;
    cyc(3);
    check("R10 rx_push after reset", rx_push, 0);
    check("R10 tx_pop after reset", tx_pop, 0);
    check("R1 miso_oe idle", miso_oe, 0);

    // table-driven transactions over all modes: R2 R3 R4 R5 R6 R7
    for (int v = 0; v < 8; v++) begin
      t = VECS[v];
      set_mode(t.cpol, t.cpha);
      rx_full = t.full;
      for (int k = 0; k < int'(t.avail); k++) begin
        txq[tx_wr % 64] = t.d0 + 8'(k);
        tx_wr++;
      end
      cyc(2);
      rx0 = rx_wr; pop0 = tx_rd;
      ss_n = 1'b0; cyc(H);
      check("R1 miso_oe selected", miso_oe, 1);
      xfer_byte(t.cmd, r);
      check("R7 R3 command-slot status", r, t.stat);
      for (int s = 0; s < 3; s++) begin
        if (t.cmd[7]) begin
          xfer_byte(8'h00, r);
          exp = (s < int'(t.avail)) ? t.d0 + 8'(s) : {6'b0, 1'b1, t.full};
          check("R6 read slot", r, exp);
        end else begin
          xfer_byte(t.d0 + 8'(s), r);
          check("R3 write slot status", r, {6'b0, 1'b1, t.full});
        end
      end
      end_xfer();
      check("R1 miso_oe released", miso_oe, 0);
      if (t.cmd[7]) begin
        check("R11 R6 pops per read", tx_rd - pop0, int'(t.avail));
        check("R2 read makes no push", rx_wr - rx0, 0);
      end else begin
        check("R5 R4 pushes per write", rx_wr - rx0, t.full ? 0 : 3);
        check("R2 write makes no pop", tx_rd - pop0, 0);
        if (!t.full)
          for (int s = 0; s < 3; s++)
            check("R4 pushed byte", rxq[(rx0 + s) % 64], t.d0 + 8'(s));
      end
    end

    // R8: configuration changed mid-transaction is ignored
    set_mode(1'b0, 1'b0);
    rx_full = 1'b0;
    rx0 = rx_wr;
    ss_n = 1'b0; cyc(H);
    xfer_byte(8'h00, r);
    cfg_cpol = 1'b1; cfg_cpha = 1'b1;
    xfer_byte(8'h5A, r);
    check("R8 status after cfg change", r, 8'h02);
    xfer_byte(8'hA5, r);
    end_xfer();
    check("R8 push count", rx_wr - rx0, 2);
    check("R8 first byte", rxq[rx0 % 64], 8'h5A);
    check("R8 second byte", rxq[(rx0 + 1) % 64], 8'hA5);

    // R9: abort mid-byte, then a fresh command
    set_mode(1'b0, 1'b0);
    rx0 = rx_wr;
    ss_n = 1'b0; cyc(H);
    xfer_byte(8'h00, r);
    xfer_byte(8'hF0, r, 4);
    ss_n = 1'b1; cyc(2 * H);
    check("R9 partial byte dropped", rx_wr - rx0, 0);
    ss_n = 1'b0; cyc(H);
    xfer_byte(8'h01, r);
    check("R9 new command slot status", r, 8'h02);
    xfer_byte(8'h3C, r);
    end_xfer();
    check("R9 push after restart", rx_wr - rx0, 1);
    check("R9 restart byte", rxq[rx0 % 64], 8'h3C);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule